// File: doc/BRIEF.md
# Embedded-Clock Frame Synchronizer

This block is the receive half of a serial link in which every word travels between two fixed framing bits: a high start bit ahead of the payload and a low stop bit behind it. Because each stop bit is followed by the next frame's start bit, the line carries a low-to-high transition at the same place in every frame period. The block takes a one-bit serial input, sampled only on cycles where a bit-rate enable is high. It finds that recurring transition on its own, with no training pattern and no special characters, so it can join a stream that is already running.

During acquisition the block treats every bit offset in the frame period as a candidate boundary. A candidate is removed as soon as the bit pair at its offset is anything other than 0 followed by 1. Random payload removes the false candidates quickly, while the true boundary survives indefinitely. Once exactly one candidate has survived the qualification window, the block declares lock. It then cuts the stream into frames at that offset and presents the payload word and sideband bits in parallel with a one-cycle valid strobe. While locked it keeps checking the framing bits and drops back to acquisition after a run of bad frames.

The frame length, payload width plus sideband width plus two, is built from the same parameters a matching serializer uses. This lets the two be connected back to back.

Top module: `embclk_frame_sync`

## Requirements
- R1: After reset, `locked_o` and `word_valid_o` are both 0.
- R2: A frame is DATA_W+SIDE_W+2 bits long and is sent as: start bit (1), payload bits least significant first, sideband bits least significant first, stop bit (0). The payload appears on `word_o[i]` and the sideband on `side_o[j]` at the same index.
- R3: From reset, with random payload and with the stream entering at any bit offset of a frame, the block locks within 2*LOCK_FRAMES+4 frames, and the words that follow are deframed correctly.
- R4: Lock is declared only after LOCK_FRAMES frame periods of search in which exactly one offset has kept a valid 0-then-1 boundary. The block therefore stays unlocked for at least the first LOCK_FRAMES-1 complete frames after reset.
- R5: When every candidate offset has been eliminated, the search restarts. A stream that cannot contain a boundary, such as constant ones, never produces lock, and a valid stream that follows it is still acquired.
- R6: While locked, each frame whose start bit is 1 and stop bit is 0 produces exactly one `word_valid_o` pulse, one cycle wide, in the cycle after the stop bit is sampled. `word_o` and `side_o` are correct for every payload, including all-zero and all-one runs, and they hold their value between pulses.
- R7: `word_valid_o` is never asserted while the block is unlocked, and it is not asserted for a locked frame with a bad start or stop bit.
- R8: While locked, fewer than LOSS_FRAMES consecutive bad frames do not drop lock, and a good frame clears the count of bad frames.
- R9: The LOSS_FRAMES-th consecutive bad frame clears `locked_o` in the cycle after its stop bit. Acquisition then restarts on its own and locks again on valid traffic.
- R10: On cycles with `bit_en` low, `ser_in` is ignored and the bit-position count does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | High on cycles where `ser_in` carries a new bit |
| ser_in | input | 1 | Serial data, sampled when `bit_en` is high |
| word_o | output | DATA_W | Deframed payload word |
| side_o | output | SIDE_W | Deframed sideband bits |
| word_valid_o | output | 1 | One-cycle strobe per good locked frame |
| locked_o | output | 1 | Frame alignment acquired |

## Verification
The hardest condition to reach from the ports is the loss-of-lock counter sitting one frame below its limit and then being cleared by a single good frame. The bench reaches it by sending whole frames with a deliberately broken stop bit, LOSS_FRAMES-1 in a row, followed by a clean frame and then a full run of bad frames. A second difficult state is the search with every candidate eliminated. A constant-ones stream produces this repeatedly, and the bench then checks that a valid stream is still acquired. Hot insertion is imitated by starting the stream partway through a frame. Junk is driven on `ser_in` during every disabled cycle.

// File: rtl/efs_pkg.sv
package efs_pkg;

    typedef enum logic {
        SYNC_HUNT   = 1'b0,
        SYNC_LOCKED = 1'b1
    } sync_state_e;

endpackage

// File: rtl/efs_bit_tracker.sv
module efs_bit_tracker #(
    parameter int FRAME_LEN = 14
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bit_en,
    input  logic                         ser_in,
    output logic [$clog2(FRAME_LEN)-1:0] phase_o,
    output logic                         prev_bit_o,
    output logic                         prev_ok_o,
    output logic [FRAME_LEN-1:0]         frame_o
);
    localparam int PW = $clog2(FRAME_LEN);
    localparam logic [PW-1:0] LAST_PHASE = PW'(FRAME_LEN - 1);

    typedef struct packed {
        logic [PW-1:0]        phase;
        logic                 prev;
        logic                 prev_ok;
        logic [FRAME_LEN-1:0] shreg;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (bit_en) begin
            trk_d.phase   = (trk_q.phase == LAST_PHASE) ? '0 : trk_q.phase + 1'b1;
            trk_d.prev    = ser_in;
            trk_d.prev_ok = 1'b1;
            trk_d.shreg   = {trk_q.shreg[FRAME_LEN-2:0], ser_in};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign phase_o    = trk_q.phase;
    assign prev_bit_o = trk_q.prev;
    assign prev_ok_o  = trk_q.prev_ok;
    // newest bit sits at index 0, the oldest of the last FRAME_LEN at the top
    assign frame_o    = {trk_q.shreg[FRAME_LEN-2:0], ser_in};

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.phase <= LAST_PHASE);                                      // R2
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(trk_q.phase));                               // R10

endmodule

// File: rtl/efs_candidate_search.sv
module efs_candidate_search #(
    parameter int FRAME_LEN   = 14,
    parameter int LOCK_FRAMES = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         enable,
    input  logic                         bit_en,
    input  logic                         cur_bit,
    input  logic                         prev_bit,
    input  logic                         prev_ok,
    input  logic [$clog2(FRAME_LEN)-1:0] phase,
    output logic                         lock_req,
    output logic [$clog2(FRAME_LEN)-1:0] lock_pos
);
    localparam int PW = $clog2(FRAME_LEN);
    localparam int FW = $clog2(LOCK_FRAMES + 1);
    localparam logic [PW-1:0] LAST_PHASE = PW'(FRAME_LEN - 1);
    localparam logic [FW-1:0] FRAME_GOAL = FW'(LOCK_FRAMES);

    typedef struct packed {
        logic [FRAME_LEN-1:0] alive;
        logic [FW-1:0]        frames;
    } srch_t;

    srch_t srch_d, srch_q;
    logic [FRAME_LEN-1:0] alive_n;
    logic [PW-1:0]        chk_pos;
    int                   survivors;

    // the previous bit is the candidate stop bit, the current one its start bit
    assign chk_pos = (phase == '0) ? LAST_PHASE : phase - 1'b1;

    always_comb begin
        srch_d  = srch_q;
        alive_n = srch_q.alive;
        if (!enable) begin
            srch_d.alive  = '1;
            srch_d.frames = '0;
        end else if (bit_en) begin
            if (prev_ok && !(!prev_bit && cur_bit)) alive_n[chk_pos] = 1'b0;
            if (alive_n == '0) begin
                srch_d.alive  = '1;
                srch_d.frames = '0;
            end else begin
                srch_d.alive = alive_n;
                if (phase == LAST_PHASE && srch_q.frames < FRAME_GOAL)
                    srch_d.frames = srch_q.frames + 1'b1;
            end
        end
    end

    always_comb begin
        survivors = 0;
        lock_pos  = '0;
        for (int i = 0; i < FRAME_LEN; i++) begin
            if (srch_q.alive[i]) begin
                survivors = survivors + 1;
                lock_pos  = PW'(i);
            end
        end
    end

    assign lock_req = enable && (srch_q.frames == FRAME_GOAL) && (survivors == 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srch_q.alive  <= '1;
            srch_q.frames <= '0;
        end else begin
            srch_q <= srch_d;
        end
    end

    AST_SURVIVOR_EXISTS: assert property (@(posedge clk) disable iff (!rst_n)
        srch_q.alive != '0);                                             // R5
    AST_WINDOW_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        srch_q.frames <= FRAME_GOAL);                                    // R4

endmodule

// File: rtl/efs_deframer.sv
module efs_deframer #(
    parameter int DATA_W = 10,
    parameter int SIDE_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DATA_W+SIDE_W+1:0] frame,
    input  logic                     frame_done,
    output logic                     good,
    output logic [DATA_W-1:0]        word_o,
    output logic [SIDE_W-1:0]        side_o,
    output logic                     valid_o
);
    localparam int FRAME_LEN = DATA_W + SIDE_W + 2;

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic [SIDE_W-1:0] side;
        logic              valid;
    } out_t;

    out_t out_d, out_q;
    logic [DATA_W-1:0] word_x;
    logic [SIDE_W-1:0] side_x;

    // start bit is the oldest bit, stop bit the newest
    assign good = frame[FRAME_LEN-1] & ~frame[0];

    always_comb begin
        for (int i = 0; i < DATA_W; i++) word_x[i] = frame[FRAME_LEN-2-i];
        for (int j = 0; j < SIDE_W; j++) side_x[j] = frame[FRAME_LEN-2-DATA_W-j];
    end

    always_comb begin
        out_d       = out_q;
        out_d.valid = frame_done & good;
        if (frame_done && good) begin
            out_d.word = word_x;
            out_d.side = side_x;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign word_o  = out_q.word;
    assign side_o  = out_q.side;
    assign valid_o = out_q.valid;

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_q.valid |-> ($stable(out_q.word) && $stable(out_q.side)));  // R6

endmodule

// File: rtl/embclk_frame_sync.sv
module embclk_frame_sync
    import efs_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int SIDE_W      = 2,
    parameter int LOCK_FRAMES = 64,
    parameter int LOSS_FRAMES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              ser_in,
    output logic [DATA_W-1:0] word_o,
    output logic [SIDE_W-1:0] side_o,
    output logic              word_valid_o,
    output logic              locked_o
);
    localparam int FRAME_LEN = DATA_W + SIDE_W + 2;
    localparam int PW        = $clog2(FRAME_LEN);
    localparam int MW        = $clog2(LOSS_FRAMES + 1);
    localparam logic [MW-1:0] MISS_LAST = MW'(LOSS_FRAMES - 1);

    typedef struct packed {
        sync_state_e   state;
        logic [PW-1:0] pos;
        logic [MW-1:0] miss;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [PW-1:0]        phase;
    logic                 prev_bit;
    logic                 prev_ok;
    logic [FRAME_LEN-1:0] frame;
    logic                 lock_req;
    logic [PW-1:0]        lock_pos;
    logic                 frame_done;
    logic                 good;

    efs_bit_tracker #(.FRAME_LEN(FRAME_LEN)) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .ser_in     (ser_in),
        .phase_o    (phase),
        .prev_bit_o (prev_bit),
        .prev_ok_o  (prev_ok),
        .frame_o    (frame)
    );

    efs_candidate_search #(
        .FRAME_LEN   (FRAME_LEN),
        .LOCK_FRAMES (LOCK_FRAMES)
    ) u_search (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (ctl_q.state == SYNC_HUNT),
        .bit_en   (bit_en),
        .cur_bit  (ser_in),
        .prev_bit (prev_bit),
        .prev_ok  (prev_ok),
        .phase    (phase),
        .lock_req (lock_req),
        .lock_pos (lock_pos)
    );

    assign frame_done = bit_en && (ctl_q.state == SYNC_LOCKED) && (phase == ctl_q.pos);

    efs_deframer #(.DATA_W(DATA_W), .SIDE_W(SIDE_W)) u_deframer (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame      (frame),
        .frame_done (frame_done),
        .good       (good),
        .word_o     (word_o),
        .side_o     (side_o),
        .valid_o    (word_valid_o)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            SYNC_HUNT: begin
                if (lock_req) begin
                    ctl_d.state = SYNC_LOCKED;
                    ctl_d.pos   = lock_pos;
                    ctl_d.miss  = '0;
                end
            end
            SYNC_LOCKED: begin
                if (frame_done) begin
                    if (good) begin
                        ctl_d.miss = '0;
                    end else if (ctl_q.miss == MISS_LAST) begin
                        ctl_d.state = SYNC_HUNT;
                        ctl_d.miss  = '0;
                    end else begin
                        ctl_d.miss = ctl_q.miss + 1'b1;
                    end
                end
            end
            default: ctl_d.state = SYNC_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.state <= SYNC_HUNT;
            ctl_q.pos   <= '0;
            ctl_q.miss  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign locked_o = (ctl_q.state == SYNC_LOCKED);

    AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> $past(locked_o));                               // R7
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |=> !word_valid_o);                                 // R6
    AST_LOCK_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(lock_req));                            // R4
    AST_LOSS_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked_o) |-> $past(frame_done && !good));                 // R9
    AST_MISS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.miss <= MISS_LAST);                                        // R8

endmodule

// File: tb/embclk_frame_sync_bench.sv
module embclk_frame_sync_bench;
    localparam int DATA_W      = 10;
    localparam int SIDE_W      = 2;
    localparam int LOCK_FRAMES = 64;
    localparam int LOSS_FRAMES = 4;
    localparam int FLEN        = DATA_W + SIDE_W + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bit_en = 1'b0;
    logic              ser_in = 1'b0;
    logic [DATA_W-1:0] word_o;
    logic [SIDE_W-1:0] side_o;
    logic              word_valid_o;
    logic              locked_o;

    int checks = 0;
    int errors = 0;
    int spurious = 0;
    int pulses = 0;
    logic [DATA_W-1:0] got_word;
    logic [SIDE_W-1:0] got_side;

    always #5 clk = ~clk;

    embclk_frame_sync #(
        .DATA_W(DATA_W), .SIDE_W(SIDE_W),
        .LOCK_FRAMES(LOCK_FRAMES), .LOSS_FRAMES(LOSS_FRAMES)
    ) u_embclk_frame_sync (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in),
        .word_o(word_o), .side_o(side_o),
        .word_valid_o(word_valid_o), .locked_o(locked_o)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        bit_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one bit: enable cycle, then a disabled cycle carrying junk (R10)
    task automatic send_bit(input logic b);
        logic lk_before;
        @(negedge clk);
        lk_before = locked_o;
        bit_en = 1'b1;
        ser_in = b;
        @(negedge clk);
        bit_en = 1'b0;
        ser_in = 1'($urandom);
        if (word_valid_o) begin
            pulses++;
            got_word = word_o;
            got_side = side_o;
            if (!lk_before) spurious++;
        end
    endtask

    task automatic send_frame(input logic [DATA_W-1:0] d, input logic [SIDE_W-1:0] s,
                              input bit bad, input int from);
        logic [FLEN-1:0] tx;
        tx[0] = 1'b1;
        for (int i = 0; i < DATA_W; i++) tx[1+i] = d[i];
        for (int j = 0; j < SIDE_W; j++) tx[1+DATA_W+j] = s[j];
        tx[FLEN-1] = bad ? 1'b1 : 1'b0;
        pulses = 0;
        for (int i = from; i < FLEN; i++) send_bit(tx[i]);
    endtask

    task automatic good_frame(input string tag, input logic [DATA_W-1:0] d, input logic [SIDE_W-1:0] s);
        send_frame(d, s, 1'b0, 0);
        check(pulses == 1, {tag, " R6 pulse count"}, pulses, 1);
        check(got_word == d, {tag, " R2 word"}, got_word, d);
        check(got_side == s, {tag, " R2 sideband"}, got_side, s);
    endtask

    task automatic acquire(input string tag, input int from, input bit check_min);
        int first_lock;
        first_lock = -1;
        send_frame(DATA_W'($urandom), SIDE_W'($urandom), 1'b0, from);
        for (int n = 0; n < 2 * LOCK_FRAMES + 4; n++) begin
            send_frame(DATA_W'($urandom), SIDE_W'($urandom), 1'b0, 0);
            if (locked_o) begin
                first_lock = n;
                break;
            end
        end
        check(first_lock >= 0, {tag, " R3 lock acquired"}, first_lock, 0);
        if (check_min)
            check(first_lock >= LOCK_FRAMES - 2, {tag, " R4 lock not early"}, first_lock, LOCK_FRAMES - 2);
        for (int k = 0; k < 6; k++)
            good_frame({tag, " R3 data after lock"}, DATA_W'($urandom), SIDE_W'($urandom));
    endtask

    task automatic t_reset();
        do_reset();
        check(locked_o == 1'b0, "R1 locked after reset", locked_o, 0);
        check(word_valid_o == 1'b0, "R1 valid after reset", word_valid_o, 0);
    endtask

    task automatic t_constant_payload();
        for (int k = 0; k < 10; k++) good_frame("R6 all zero", '0, '0);
        for (int k = 0; k < 10; k++) good_frame("R6 all one", '1, '1);
        check(locked_o == 1'b1, "R6 lock kept over runs", locked_o, 1);
    endtask

    task automatic t_loss();
        for (int k = 0; k < LOSS_FRAMES - 1; k++) begin
            send_frame(DATA_W'($urandom), SIDE_W'($urandom), 1'b1, 0);
            check(pulses == 0, "R7 no valid on bad frame", pulses, 0);
            check(locked_o == 1'b1, "R8 lock held below limit", locked_o, 1);
        end
        good_frame("R8 good frame clears count", 10'h2a5, 2'b10);
        for (int k = 0; k < LOSS_FRAMES - 1; k++)
            send_frame(DATA_W'($urandom), SIDE_W'($urandom), 1'b1, 0);
        check(locked_o == 1'b1, "R8 count was cleared", locked_o, 1);
        send_frame(DATA_W'($urandom), SIDE_W'($urandom), 1'b1, 0);
        check(locked_o == 1'b0, "R9 lock dropped", locked_o, 0);
        acquire("R9 reacquire", 0, 1'b0);
    endtask

    task automatic t_restart();
        do_reset();
        for (int k = 0; k < 100 * FLEN; k++) send_bit(1'b1);
        check(locked_o == 1'b0, "R5 no lock on constant ones", locked_o, 0);
        acquire("R5 after restart", 0, 1'b0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        acquire("R3 aligned start", 0, 1'b1);
        t_constant_payload();
        t_loss();
        do_reset();
        acquire("R3 hot insertion", 5, 1'b1);
        t_restart();
        check(spurious == 0, "R7 valid while unlocked", spurious, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule